// File: doc/BRIEF.md
# Serial Memory Clock-Count Write Guard

This block sits beside the command decoder of a three-wire serial memory and protects its array from frames corrupted by a spurious clock edge. From the cycle in which the start bit is detected until chip select drops, it counts the serial clock edges. It then compares the count with the exact frame length that the decoded command must have, given the current organization (8-bit or 16-bit words). When chip select falls it issues a single-cycle execute pulse if the two agree, or a reject pulse if they do not. A frame shifted by one glitch clock therefore never starts a programming cycle at a wrong address.

The input `sclk_rise` is a one-cycle strobe for each rising edge of the serial clock, already synchronized to `clk`. The input `start_seen` is pulsed together with the `sclk_rise` strobe that sampled the start bit. Only the four array-modifying commands are judged: single write, single erase, erase-all and write-all. Read, enable and disable frames produce neither pulse.

Top module: `wr_pulse_guard`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `exec_p` and `reject_p` are both 0.
- R2: With `org`=0 (8-bit words), a single write (`cmd_class`=2) whose frame holds exactly 20 counted edges (start bit as edge 1, 2 opcode, 9 address, 8 data) yields `exec_p`.
- R3: With `org`=1 (16-bit words), a single write holding exactly 27 counted edges (1 + 2 + 8 address + 16 data) yields `exec_p`.
- R4: A single erase (`cmd_class`=3) or an erase-all (`cmd_class`=4) yields `exec_p` at exactly 12 edges with `org`=0 and at exactly 11 edges with `org`=1.
- R5: A write-all (`cmd_class`=5) expects the same length as a single write in the same organization.
- R6: For a judged command, any other count, including one too many or one too few, yields `reject_p` and no `exec_p`.
- R7: Read (`cmd_class`=1), enable (6), disable (7) and no-command (0) frames yield neither pulse, whatever the count.
- R8: The edge count saturates. A frame far longer than any valid length (for example 52 edges) is rejected and never wraps back to a valid count.
- R9: The pulse is high for exactly the one cycle after the first `clk` edge at which `cs` is seen low following a high. `exec_p` and `reject_p` are never high together.
- R10: Counting begins at the `start_seen` edge. Serial clock edges before the start bit, or while `cs` is low, are not counted, and every frame starts from a cleared count.
- R11: The judgement uses `cmd_class` and `org` as they were in the last cycle with `cs` high. Changes on those inputs once `cs` is low do not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_rise | input | 1 | One-cycle strobe per serial clock rising edge |
| cs | input | 1 | Chip select level, high during a frame |
| start_seen | input | 1 | Strobe marking the edge that sampled the start bit |
| cmd_class | input | 3 | Decoded command: 0 none, 1 read, 2 write, 3 erase, 4 erase-all, 5 write-all, 6 enable, 7 disable |
| org | input | 1 | Organization: 0 = 8-bit words, 1 = 16-bit words |
| exec_p | output | 1 | One-cycle grant for a judged command with a matching count |
| reject_p | output | 1 | One-cycle refusal for a judged command with a mismatching count |

## Verification
The bench feeds every judged command at its exact length in both organizations. It also feeds lengths one below and one above, which separates a correct exact-match test from an off-by-one or a "greater or equal" comparison. A length that is valid only for the other organization shows that `org` actually selects the expected value. A 52-edge frame tells saturation apart from wrap-around. Unjudged commands run at lengths that would be valid for a write, to show that they are ignored. Extra clock edges before the start bit, edges while `cs` is low, and a command and organization change in the same cycle `cs` falls show that counting and sampling begin and end at the right points.

// File: rtl/wpg_pkg.sv
// Shared command encoding for the clock-count write guard.
// Assumes the decoder presents one of these codes on cmd_class.
package wpg_pkg;
    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_READ   = 3'd1,
        CMD_WRITE  = 3'd2,
        CMD_ERASE  = 3'd3,
        CMD_ER_ALL = 3'd4,
        CMD_WR_ALL = 3'd5,
        CMD_WR_EN  = 3'd6,
        CMD_WR_DIS = 3'd7
    } cmd_e;
endpackage

// File: rtl/wpg_edge_counter.sv
// Counts serial clock edges from the start bit until chip select drops.
// Assumes start_seen coincides with the sclk_rise strobe of the start bit.
// The count saturates at all-ones and clears whenever cs is low.
module wpg_edge_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             sclk_rise,
    input  logic             start_seen,
    output logic [CNT_W-1:0] cnt,
    output logic             armed
);
    localparam logic [CNT_W-1:0] SAT = '1;

    // Load on start bit, then saturating increment per serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (sclk_rise) begin
            if (!armed && start_seen) begin
                cnt   <= CNT_W'(1);
                armed <= 1'b1;
            end else if (armed && cnt != SAT) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && cnt == SAT) |=> (cnt == SAT || cnt == '0));

    // R10
    cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (cnt == '0 && !armed));
endmodule

// File: rtl/wpg_len_table.sv
// Gives the exact frame length each command must have, per organization,
// and whether the command is judged at all. Purely combinational.
module wpg_len_table
    import wpg_pkg::*;
#(
    parameter int OP_W   = 2,
    parameter int AW_X8  = 9,
    parameter int AW_X16 = 8,
    parameter int DW_X8  = 8,
    parameter int DW_X16 = 16,
    parameter int CNT_W  = 5
) (
    input  cmd_e             cls,
    input  logic             org,
    output logic             judged,
    output logic [CNT_W-1:0] exp_len
);
    localparam int HDR_X8  = 1 + OP_W + AW_X8;
    localparam int HDR_X16 = 1 + OP_W + AW_X16;

    // Pick the header-only or header-plus-data length.
    always_comb begin
        judged  = 1'b0;
        exp_len = '0;
        unique case (cls)
            CMD_ERASE, CMD_ER_ALL: begin
                judged  = 1'b1;
                exp_len = org ? CNT_W'(HDR_X16) : CNT_W'(HDR_X8);
            end
            CMD_WRITE, CMD_WR_ALL: begin
                judged  = 1'b1;
                exp_len = org ? CNT_W'(HDR_X16 + DW_X16) : CNT_W'(HDR_X8 + DW_X8);
            end
            default: begin
                judged  = 1'b0;
                exp_len = '0;
            end
        endcase
    end
endmodule

// File: rtl/wpg_judge.sv
// Detects the chip select fall and issues the execute or reject pulse.
// Assumes cnt/armed still hold the frame's values in the first cs-low cycle.
module wpg_judge
    import wpg_pkg::*;
#(
    parameter int OP_W   = 2,
    parameter int AW_X8  = 9,
    parameter int AW_X16 = 8,
    parameter int DW_X8  = 8,
    parameter int DW_X16 = 16,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  cmd_e             cls,
    input  logic             org,
    input  logic [CNT_W-1:0] cnt,
    input  logic             armed,
    output logic             exec_p,
    output logic             reject_p
);
    logic             cs_q;
    cmd_e             cls_q;
    logic             org_q;
    logic             judged;
    logic [CNT_W-1:0] exp_len;
    logic             cs_fall;

    // Hold command and organization as seen in the last cs-high cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b0;
            cls_q <= CMD_NONE;
            org_q <= 1'b0;
        end else begin
            cs_q <= cs;
            if (cs) begin
                cls_q <= cls;
                org_q <= org;
            end
        end
    end

    wpg_len_table #(
        .OP_W(OP_W), .AW_X8(AW_X8), .AW_X16(AW_X16),
        .DW_X8(DW_X8), .DW_X16(DW_X16), .CNT_W(CNT_W)
    ) len_i (
        .cls(cls_q), .org(org_q), .judged(judged), .exp_len(exp_len)
    );

    assign cs_fall = cs_q && !cs;

    // Register the verdict for one cycle after the cs fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_p   <= 1'b0;
            reject_p <= 1'b0;
        end else begin
            exec_p   <= cs_fall && armed && judged && (cnt == exp_len);
            reject_p <= cs_fall && armed && judged && (cnt != exp_len);
        end
    end

    // R9
    excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_p && reject_p));

    // R9
    single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_p || reject_p) |=> !(exec_p || reject_p));

    // R9
    after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_p || reject_p) |-> (!$past(cs) && $past(cs_q)));

    // R7
    judged_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_p || reject_p) |-> $past(judged));
endmodule

// File: rtl/wr_pulse_guard.sv
// Top of the clock-count write guard: counts serial edges per frame and
// grants or refuses array-modifying commands at chip select deassertion.
// Assumes all inputs are synchronous to clk.
module wr_pulse_guard #(
    parameter int OP_W   = 2,
    parameter int AW_X8  = 9,
    parameter int AW_X16 = 8,
    parameter int DW_X8  = 8,
    parameter int DW_X16 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_rise,
    input  logic       cs,
    input  logic       start_seen,
    input  logic [2:0] cmd_class,
    input  logic       org,
    output logic       exec_p,
    output logic       reject_p
);
    import wpg_pkg::*;

    localparam int LEN_X8  = 1 + OP_W + AW_X8 + DW_X8;
    localparam int LEN_X16 = 1 + OP_W + AW_X16 + DW_X16;
    localparam int LEN_MAX = (LEN_X8 > LEN_X16) ? LEN_X8 : LEN_X16;
    localparam int CNT_W   = $clog2(LEN_MAX + 2);

    logic [CNT_W-1:0] cnt;
    logic             armed;
    cmd_e             cls;

    assign cls = cmd_e'(cmd_class);

    wpg_edge_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk_rise(sclk_rise),
        .start_seen(start_seen), .cnt(cnt), .armed(armed)
    );

    wpg_judge #(
        .OP_W(OP_W), .AW_X8(AW_X8), .AW_X16(AW_X16),
        .DW_X8(DW_X8), .DW_X16(DW_X16), .CNT_W(CNT_W)
    ) judge_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .cls(cls), .org(org),
        .cnt(cnt), .armed(armed), .exec_p(exec_p), .reject_p(reject_p)
    );
endmodule

// File: tb/wr_pulse_guard_tb_top.sv
`timescale 1ns/1ps
module wr_pulse_guard_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_rise = 1'b0;
    logic cs = 1'b0;
    logic start_seen = 1'b0;
    logic [2:0] cmd_class = 3'd0;
    logic org = 1'b0;
    logic exec_p, reject_p;
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    wr_pulse_guard dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .cs(cs),
        .start_seen(start_seen), .cmd_class(cmd_class), .org(org),
        .exec_p(exec_p), .reject_p(reject_p)
    );

    // vector: {org, class, edges, exec expected, reject expected}
    localparam int NV = 21;
    localparam logic [12:0] VT [NV] = '{
        {1'b0, 3'd2, 7'd20, 1'b1, 1'b0},  // R2
        {1'b0, 3'd2, 7'd19, 1'b0, 1'b1},  // R6
        {1'b0, 3'd2, 7'd21, 1'b0, 1'b1},  // R6
        {1'b1, 3'd2, 7'd27, 1'b1, 1'b0},  // R3
        {1'b1, 3'd2, 7'd26, 1'b0, 1'b1},  // R6
        {1'b1, 3'd2, 7'd28, 1'b0, 1'b1},  // R6
        {1'b1, 3'd2, 7'd20, 1'b0, 1'b1},  // R6 wrong org length
        {1'b0, 3'd3, 7'd12, 1'b1, 1'b0},  // R4
        {1'b1, 3'd3, 7'd11, 1'b1, 1'b0},  // R4
        {1'b0, 3'd4, 7'd12, 1'b1, 1'b0},  // R4
        {1'b1, 3'd4, 7'd11, 1'b1, 1'b0},  // R4
        {1'b1, 3'd4, 7'd12, 1'b0, 1'b1},  // R6
        {1'b0, 3'd5, 7'd20, 1'b1, 1'b0},  // R5
        {1'b1, 3'd5, 7'd27, 1'b1, 1'b0},  // R5
        {1'b0, 3'd5, 7'd27, 1'b0, 1'b1},  // R5 x16 length in x8
        {1'b0, 3'd1, 7'd20, 1'b0, 1'b0},  // R7
        {1'b0, 3'd6, 7'd12, 1'b0, 1'b0},  // R7
        {1'b1, 3'd7, 7'd11, 1'b0, 1'b0},  // R7
        {1'b0, 3'd0, 7'd20, 1'b0, 1'b0},  // R7
        {1'b0, 3'd2, 7'd52, 1'b0, 1'b1},  // R8
        {1'b1, 3'd5, 7'd59, 1'b0, 1'b1}   // R8
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Frame: pre edges before the start bit, then n counted edges.
    // cmd_class and org are changed as cs drops (R11).
    task automatic frame(input logic o, input logic [2:0] c, input int n,
                         input int pre, input logic ee, input logic er,
                         input string req);
        @(negedge clk);
        cs = 1'b1; org = o; cmd_class = c;
        for (int i = 0; i < pre + n; i++) begin
            @(negedge clk);
            sclk_rise = 1'b1; start_seen = (i == pre);
            @(negedge clk);
            sclk_rise = 1'b0; start_seen = 1'b0;
            @(negedge clk);
        end
        cs = 1'b0; cmd_class = 3'd0; org = ~o;
        check({req, " pulse early"}, exec_p | reject_p, 1'b0);
        @(negedge clk);
        check({req, " exec"}, exec_p, ee);
        check({req, " reject"}, reject_p, er);
        @(negedge clk);
        check({req, " R9 single cycle"}, exec_p | reject_p, 1'b0);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset exec", exec_p, 1'b0);
        check("R1 reset reject", reject_p, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset exec", exec_p, 1'b0);
        check("R1 post-reset reject", reject_p, 1'b0);

        for (int v = 0; v < NV; v++) begin
            frame(VT[v][12], VT[v][11:9], int'(VT[v][8:2]), 0,
                  VT[v][1], VT[v][0], $sformatf("vec%0d", v));
        end

        // R10: edges before the start bit are not counted
        frame(1'b0, 3'd2, 20, 5, 1'b1, 1'b0, "R10 pre-start");
        // R10: edges while cs low are ignored; next frame starts cleared
        for (int i = 0; i < 7; i++) begin
            @(negedge clk); sclk_rise = 1'b1; start_seen = (i == 0);
            @(negedge clk); sclk_rise = 1'b0; start_seen = 1'b0;
        end
        check("R10 cs-low edges", exec_p | reject_p, 1'b0);
        frame(1'b1, 3'd3, 11, 0, 1'b1, 1'b0, "R10 fresh frame");
        // R11: late class change covered in every frame; x16 erase-all again
        frame(1'b1, 3'd4, 11, 0, 1'b1, 1'b0, "R11 sampled class");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule